// File: doc/BRIEF.md
# Serial Receiver with Error-Tagged Character Queue

This block turns an asynchronous serial input into a queue of received characters. A free-running oversampling strobe paces a small frame sequencer. The sequencer confirms a start bit at the middle of its bit period, then samples each data, parity and stop bit at its centre. Every finished character is written into a first-in first-out queue as one 10-bit word. The parity and framing error marks are stored in the same word as the data, so the reader always sees the errors together with the character they belong to.

Four frame formats are selectable: 8 data bits, 7 data bits with parity, 8 data bits with parity, and 9 data bits. The reader pops the oldest word with a one-cycle read strobe. Status outputs report:
- that the queue holds data,
- that it is at least half full,
- that a character was lost because the queue was full,
- that buffered data has sat unread for a programmable number of character times.

A receive enable gates the sequencer, and a reset strobe empties the queue.

Top module: `uart_rx_fifo`

## Requirements
- R1: Frames are one start bit (low), then the data bits least significant bit first, then an optional parity bit, then one stop bit (high). The format is set by `frameMode`: 0 = 8 data bits without parity, 1 = 7 data bits with parity, 2 = 8 data bits with parity, 3 = 9 data bits without parity.
- R2: Each stored word holds the received data in bits 7:0, with bit 7 zero in format 1. Bit 8 is data bit 8 in format 3, the parity error mark in formats 1 and 2, and zero in format 0. Bit 9 is set when the stop bit was sampled low.
- R3: The parity check expects an even count of ones over the data and parity bits when `parityOdd` is 0, and an odd count when it is 1. A mismatch sets word bit 8.
- R4: A start bit is accepted only if the line is still low at the half-bit sample, 8 ticks after the falling edge. A shorter low pulse stores nothing.
- R5: A line held low through the whole frame is stored as 10'h200, with no parity error in either parity sense. A new frame starts only after the line has returned high and then fallen again.
- R6: `readData` shows the oldest stored word while `notEmpty` is 1. A cycle with `readStrobe` high removes that word. Words leave in arrival order. A read strobe while the queue is empty has no effect.
- R7: `halfFull` is 1 exactly when DEPTH/2 or more words are stored.
- R8: A character that completes while DEPTH words are stored is discarded, the stored words are kept unchanged, and `overrun` is set. `overrun` clears when a word is read.
- R9: One character time is the frame length in bits times OVERSAMPLE ticks. `timeoutFlag` rises once `timeoutChars` character times have passed with the queue non-empty and no character arriving and no read. Each arrival or read restarts the count. The flag is 0 while the queue is empty and whenever `timeoutChars` is 0.
- R10: While `rxEnable` is 0, nothing is received and any frame in progress is abandoned.
- R11: A `rxReset` pulse empties the queue and clears `overrun` and `timeoutFlag`.
- R12: After reset, `notEmpty`, `halfFull`, `overrun` and `timeoutFlag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxLine | input | 1 | Serial input, idle high |
| tick16 | input | 1 | Oversampling strobe, OVERSAMPLE pulses per bit |
| frameMode | input | 2 | Frame format select |
| parityOdd | input | 1 | 1 selects odd parity, 0 selects even parity |
| rxEnable | input | 1 | Enables reception |
| readStrobe | input | 1 | Removes the oldest word |
| timeoutChars | input | 8 | Idle limit in character times, 0 disables |
| rxReset | input | 1 | Empties the queue and clears the status flags |
| readData | output | 10 | Oldest stored word |
| notEmpty | output | 1 | At least one word is stored |
| halfFull | output | 1 | DEPTH/2 or more words are stored |
| overrun | output | 1 | A character was lost because the queue was full |
| timeoutFlag | output | 1 | Stored data has been left unread too long |

## Verification
The bench uses the default OVERSAMPLE of 16 and DEPTH of 16, and holds the tick high every cycle, so one bit lasts 16 clocks and one 10-bit frame lasts 160. With these values, seventeen back-to-back frames reach the half-full threshold at the eighth word and overrun at the seventeenth. A two-character timeout opens in about 320 cycles, which lets the bench check both sides of that boundary. All four formats, both parity senses, bad stop bits, a break, a short glitch and mid-stream reads are covered in the same run.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [1:0] {
    FMT_8N = 2'd0,
    FMT_7P = 2'd1,
    FMT_8P = 2'd2,
    FMT_9N = 2'd3
  } fmt_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } rxState_e;

  // strobes from the frame sequencer to the datapath
  typedef struct packed {
    logic startFrame;
    logic shiftData;
    logic takeParity;
    logic commit;
    logic bitValue;
  } rxStrobe_t;

  localparam int WORD_W = 10;

  function automatic logic [3:0] dataBitsOf(input logic [1:0] fmt);
    case (fmt)
      FMT_7P:  return 4'd7;
      FMT_9N:  return 4'd9;
      default: return 4'd8;
    endcase
  endfunction

  function automatic logic hasParity(input logic [1:0] fmt);
    return (fmt == FMT_7P) || (fmt == FMT_8P);
  endfunction

endpackage

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxLine,
  input  logic       tick,
  input  logic [1:0] fmt,
  input  logic       rxEnable,
  input  logic       rxReset,
  input  logic       readPop,
  input  logic       fifoNotEmpty,
  input  logic [7:0] timeoutChars,
  output rxStrobe_t  strobe,
  output logic       timeoutFlag
);

  localparam int BIT_W   = $clog2(OVERSAMPLE);
  localparam int HALF    = OVERSAMPLE / 2;
  localparam int FRAME_W = $clog2(OVERSAMPLE * 12 + 1);

  logic [SYNC_STAGES-1:0] syncReg;
  logic lineSync, prevLine, fallEdge;
  rxState_e state, stateNext;
  logic [BIT_W-1:0] tickCnt, tickNext;
  logic [3:0] bitIdx, bitNext;
  logic fullBit;

  // input synchronizer, length chosen by parameter
  generate
    if (SYNC_STAGES > 1) begin : g_sync_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncReg <= '1;
        else       syncReg <= {syncReg[SYNC_STAGES-2:0], rxLine};
      end
    end else begin : g_sync_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncReg <= '1;
        else       syncReg <= rxLine;
      end
    end
  endgenerate

  assign lineSync = syncReg[SYNC_STAGES-1];
  assign fallEdge = prevLine && !lineSync;
  assign fullBit  = tick && (tickCnt == BIT_W'(OVERSAMPLE - 1));

  always_comb begin
    stateNext = state;
    tickNext  = tickCnt;
    bitNext   = bitIdx;
    strobe    = '0;
    strobe.bitValue = lineSync;
    if (!rxEnable || rxReset) begin
      stateNext = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: begin
          if (fallEdge) begin
            stateNext = ST_START;
            tickNext  = '0;
            strobe.startFrame = 1'b1;
          end
        end
        ST_START: begin
          if (tick) begin
            if (tickCnt == BIT_W'(HALF - 1)) begin
              if (!lineSync) begin
                stateNext = ST_DATA;
                tickNext  = '0;
                bitNext   = '0;
              end else begin
                stateNext = ST_IDLE;
              end
            end else begin
              tickNext = tickCnt + 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (fullBit) begin
            strobe.shiftData = 1'b1;
            tickNext = '0;
            if (bitIdx == dataBitsOf(fmt) - 4'd1)
              stateNext = hasParity(fmt) ? ST_PARITY : ST_STOP;
            else
              bitNext = bitIdx + 4'd1;
          end else if (tick) begin
            tickNext = tickCnt + 1'b1;
          end
        end
        ST_PARITY: begin
          if (fullBit) begin
            strobe.takeParity = 1'b1;
            tickNext  = '0;
            stateNext = ST_STOP;
          end else if (tick) begin
            tickNext = tickCnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (fullBit) begin
            strobe.commit = 1'b1;
            tickNext  = '0;
            stateNext = ST_IDLE;
          end else if (tick) begin
            tickNext = tickCnt + 1'b1;
          end
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      tickCnt  <= '0;
      bitIdx   <= '0;
      prevLine <= 1'b1;
    end else begin
      state    <= stateNext;
      tickCnt  <= tickNext;
      bitIdx   <= bitNext;
      prevLine <= lineSync;
    end
  end

  // idle timeout measured in whole character times
  logic [FRAME_W-1:0] frameTicks, charTick;
  logic [7:0] charCnt;
  logic restart;

  assign frameTicks = FRAME_W'(OVERSAMPLE * (32'(dataBitsOf(fmt)) + 32'(hasParity(fmt)) + 2));
  assign restart    = strobe.commit || readPop || rxReset || !fifoNotEmpty;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      charTick <= '0;
      charCnt  <= '0;
    end else if (restart) begin
      charTick <= '0;
      charCnt  <= '0;
    end else if (tick && charCnt != 8'hFF) begin
      if (charTick == frameTicks - 1'b1) begin
        charTick <= '0;
        charCnt  <= charCnt + 8'd1;
      end else begin
        charTick <= charTick + 1'b1;
      end
    end
  end

  assign timeoutFlag = (timeoutChars != 8'd0) && fifoNotEmpty && (charCnt >= timeoutChars);

  // R10: a disabled receiver sits idle
  a_r10_disabled_idle: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> state == ST_IDLE);

  // R9: an arriving character restarts the idle count
  a_r9_restart_on_arrival: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> !timeoutFlag);

  // R4: data sampling only begins after a confirmed low start bit
  a_r4_start_confirmed: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_START && stateNext == ST_DATA) |=> $past(!lineSync));

endmodule

// File: rtl/uart_rx_datapath.sv
module uart_rx_datapath
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        fmt,
  input  logic              parityOdd,
  input  logic              rxReset,
  input  logic              readPop,
  input  rxStrobe_t         strobe,
  output logic [WORD_W-1:0] readData,
  output logic              notEmpty,
  output logic              halfFull,
  output logic              overrun
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [8:0] shiftReg;
  logic parAcc, parBit;
  logic [8:0] aligned;
  logic frameErr, isBreak, parErr;
  logic [WORD_W-1:0] word;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parAcc   <= 1'b0;
      parBit   <= 1'b0;
    end else if (strobe.startFrame) begin
      shiftReg <= '0;
      parAcc   <= 1'b0;
      parBit   <= 1'b0;
    end else if (strobe.shiftData) begin
      shiftReg <= {strobe.bitValue, shiftReg[8:1]};
      parAcc   <= parAcc ^ strobe.bitValue;
    end else if (strobe.takeParity) begin
      parBit   <= strobe.bitValue;
      parAcc   <= parAcc ^ strobe.bitValue;
    end
  end

  always_comb begin
    case (dataBitsOf(fmt))
      4'd7:    aligned = {2'b00, shiftReg[8:2]};
      4'd9:    aligned = shiftReg;
      default: aligned = {1'b0, shiftReg[8:1]};
    endcase
    frameErr = !strobe.bitValue;
    isBreak  = frameErr && (shiftReg == 9'd0) && !parBit;
    parErr   = hasParity(fmt) && !isBreak && (parAcc ^ parityOdd);
    word     = {frameErr, (fmt == FMT_9N) ? aligned[8] : parErr, aligned[7:0]};
  end

  // character queue
  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic isFull, pop, push, dropEvt;

  assign isFull  = (count == CNT_W'(DEPTH));
  assign pop     = readPop && !rxReset;
  assign push    = strobe.commit && !rxReset && (!isFull || pop);
  assign dropEvt = strobe.commit && !rxReset && isFull && !pop;

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= word;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      count   <= '0;
      overrun <= 1'b0;
    end else if (rxReset) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      count   <= '0;
      overrun <= 1'b0;
    end else begin
      if (push) wrPtr <= wrPtr + 1'b1;
      if (pop)  rdPtr <= rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (dropEvt)  overrun <= 1'b1;
      else if (pop) overrun <= 1'b0;
    end
  end

  assign readData = mem[rdPtr];
  assign notEmpty = (count != '0);
  assign halfFull = (count >= CNT_W'(DEPTH / 2));

  // R6: queue occupancy stays within its depth
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  // R6: an empty queue has matching pointers
  a_r6_empty_ptrs: assert property (@(posedge clk) disable iff (!rstN)
    (count == '0) |-> (wrPtr == rdPtr));

  // R8: overrun only rises after an arrival at a full queue
  a_r8_rise_when_full: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(isFull && strobe.commit));

  // R8: a dropped character leaves the pointers untouched
  a_r8_drop_keeps: assert property (@(posedge clk) disable iff (!rstN)
    dropEvt |=> $stable(wrPtr) && $stable(rdPtr));

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxLine,
  input  logic        tick16,
  input  logic [1:0]  frameMode,
  input  logic        parityOdd,
  input  logic        rxEnable,
  input  logic        readStrobe,
  input  logic [7:0]  timeoutChars,
  input  logic        rxReset,
  output logic [9:0]  readData,
  output logic        notEmpty,
  output logic        halfFull,
  output logic        overrun,
  output logic        timeoutFlag
);

  rxStrobe_t strobe;
  logic readPop;

  assign readPop = readStrobe && notEmpty;

  uart_rx_ctrl #(
    .OVERSAMPLE (OVERSAMPLE),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .rxLine      (rxLine),
    .tick        (tick16),
    .fmt         (frameMode),
    .rxEnable    (rxEnable),
    .rxReset     (rxReset),
    .readPop     (readPop),
    .fifoNotEmpty(notEmpty),
    .timeoutChars(timeoutChars),
    .strobe      (strobe),
    .timeoutFlag (timeoutFlag)
  );

  uart_rx_datapath #(
    .DEPTH(DEPTH)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .fmt      (frameMode),
    .parityOdd(parityOdd),
    .rxReset  (rxReset),
    .readPop  (readPop),
    .strobe   (strobe),
    .readData (readData),
    .notEmpty (notEmpty),
    .halfFull (halfFull),
    .overrun  (overrun)
  );

endmodule

// File: tb/uart_rx_fifo_test.sv
`timescale 1ns/1ps
module uart_rx_fifo_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxLine = 1'b1;
  logic tick16 = 1'b1;
  logic [1:0] frameMode = 2'd0;
  logic parityOdd = 1'b0;
  logic rxEnable = 1'b1;
  logic readStrobe = 1'b0;
  logic [7:0] timeoutChars = 8'd0;
  logic rxReset = 1'b0;
  logic [9:0] readData;
  logic notEmpty, halfFull, overrun, timeoutFlag;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  uart_rx_fifo uut (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .tick16(tick16),
    .frameMode(frameMode), .parityOdd(parityOdd), .rxEnable(rxEnable),
    .readStrobe(readStrobe), .timeoutChars(timeoutChars), .rxReset(rxReset),
    .readData(readData), .notEmpty(notEmpty), .halfFull(halfFull),
    .overrun(overrun), .timeoutFlag(timeoutFlag)
  );

  typedef struct packed {
    logic [1:0] m;
    logic       odd;
    logic [8:0] d;
    logic       flip;
    logic       bad;
    logic [9:0] exp;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'd0, 1'b0, 9'h0A5, 1'b0, 1'b0, 10'h0A5},
    '{2'd1, 1'b0, 9'h053, 1'b0, 1'b0, 10'h053},
    '{2'd1, 1'b1, 9'h035, 1'b1, 1'b0, 10'h135},
    '{2'd2, 1'b0, 9'h0C3, 1'b0, 1'b0, 10'h0C3},
    '{2'd2, 1'b1, 9'h07E, 1'b1, 1'b0, 10'h17E},
    '{2'd3, 1'b0, 9'h1A6, 1'b0, 1'b0, 10'h1A6},
    '{2'd0, 1'b0, 9'h03C, 1'b0, 1'b1, 10'h23C},
    '{2'd2, 1'b0, 9'h081, 1'b1, 1'b1, 10'h381}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [1:0] m, input logic odd, input logic [8:0] d,
                           input logic flip, input logic bad);
    int n;
    logic px;
    n  = (m == 2'd1) ? 7 : (m == 2'd3) ? 9 : 8;
    px = 1'b0;
    frameMode = m;
    parityOdd = odd;
    rxLine = 1'b0;
    waitCycles(16);
    for (int i = 0; i < n; i++) begin
      rxLine = d[i];
      px = px ^ d[i];
      waitCycles(16);
    end
    if (m == 2'd1 || m == 2'd2) begin
      rxLine = px ^ odd ^ flip;
      waitCycles(16);
    end
    rxLine = !bad;
    waitCycles(16);
    rxLine = 1'b1;
    if (bad) waitCycles(16);
  endtask

  task automatic popOne();
    readStrobe = 1'b1;
    @(negedge clk);
    readStrobe = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    waitCycles(3);
    rstN = 1'b1;
    waitCycles(2);
    // R12 reset state
    check("R12 notEmpty", notEmpty, 0);
    check("R12 halfFull", halfFull, 0);
    check("R12 overrun", overrun, 0);
    check("R12 timeoutFlag", timeoutFlag, 0);

    // R1 R2 R3 format table
    for (int v = 0; v < 8; v++) begin
      sendFrame(VECS[v].m, VECS[v].odd, VECS[v].d, VECS[v].flip, VECS[v].bad);
      waitCycles(4);
      check("R6 notEmpty after frame", notEmpty, 1);
      check("R1 R2 R3 word", readData, VECS[v].exp);
      popOne();
      check("R6 empty after read", notEmpty, 0);
    end

    // R4 short glitch is not a start bit
    frameMode = 2'd0;
    rxLine = 1'b0;
    waitCycles(4);
    rxLine = 1'b1;
    waitCycles(200);
    check("R4 glitch stores nothing", notEmpty, 0);

    // R5 break in odd parity format
    frameMode = 2'd2;
    parityOdd = 1'b1;
    rxLine = 1'b0;
    waitCycles(16 * 11 + 40);
    check("R5 break stored once", notEmpty, 1);
    check("R5 break word", readData, 10'h200);
    popOne();
    check("R5 no refire while low", notEmpty, 0);
    waitCycles(40);
    check("R5 still one word only", notEmpty, 0);
    rxLine = 1'b1;
    waitCycles(20);

    // R6 read on empty has no effect
    popOne();
    sendFrame(2'd0, 1'b0, 9'h05A, 1'b0, 1'b0);
    waitCycles(4);
    check("R6 head after empty read", readData, 10'h05A);
    popOne();
    check("R6 empty again", notEmpty, 0);

    // R7 R8 fill, half, overrun
    for (int i = 0; i < 16; i++) begin
      sendFrame(2'd0, 1'b0, 9'(i), 1'b0, 1'b0);
      waitCycles(2);
      if (i == 6) check("R7 below half", halfFull, 0);
      if (i == 7) check("R7 at half", halfFull, 1);
    end
    check("R8 no overrun when just full", overrun, 0);
    sendFrame(2'd0, 1'b0, 9'h0FF, 1'b0, 1'b0);
    waitCycles(2);
    check("R8 overrun set", overrun, 1);
    check("R8 head preserved", readData, 10'h000);
    for (int i = 0; i < 16; i++) begin
      check("R8 R6 order kept", readData, 32'(i));
      popOne();
      if (i == 0) check("R8 overrun cleared by read", overrun, 0);
    end
    check("R8 dropped word absent", notEmpty, 0);

    // R9 timeout
    timeoutChars = 8'd2;
    sendFrame(2'd0, 1'b0, 9'h011, 1'b0, 1'b0);
    waitCycles(250);
    check("R9 not yet", timeoutFlag, 0);
    waitCycles(150);
    check("R9 raised", timeoutFlag, 1);
    popOne();
    check("R9 clear when empty", timeoutFlag, 0);
    sendFrame(2'd0, 1'b0, 9'h022, 1'b0, 1'b0);
    sendFrame(2'd0, 1'b0, 9'h033, 1'b0, 1'b0);
    waitCycles(400);
    check("R9 raised two", timeoutFlag, 1);
    popOne();
    check("R9 read restarts", timeoutFlag, 0);
    check("R9 data remains", notEmpty, 1);
    waitCycles(250);
    check("R9 restarted count", timeoutFlag, 0);
    waitCycles(150);
    check("R9 raised again", timeoutFlag, 1);
    popOne();
    timeoutChars = 8'd0;
    sendFrame(2'd0, 1'b0, 9'h044, 1'b0, 1'b0);
    waitCycles(400);
    check("R9 zero disables", timeoutFlag, 0);
    popOne();

    // R10 receive disabled
    rxEnable = 1'b0;
    sendFrame(2'd0, 1'b0, 9'h066, 1'b0, 1'b0);
    waitCycles(4);
    check("R10 nothing when disabled", notEmpty, 0);
    rxEnable = 1'b1;
    waitCycles(4);

    // R11 flush
    for (int i = 0; i < 17; i++) sendFrame(2'd0, 1'b0, 9'(i + 32), 1'b0, 1'b0);
    waitCycles(2);
    check("R11 precondition overrun", overrun, 1);
    rxReset = 1'b1;
    @(negedge clk);
    rxReset = 1'b0;
    check("R11 flushed", notEmpty, 0);
    check("R11 overrun cleared", overrun, 0);
    check("R11 halfFull cleared", halfFull, 0);
    sendFrame(2'd0, 1'b0, 9'h077, 1'b0, 1'b0);
    waitCycles(4);
    check("R11 fresh head", readData, 10'h077);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule